// File: doc/BRIEF.md
# USB Host Endpoint Frame Timer

This block times one receive endpoint of a USB host in units of frames. It holds an 8-bit interval setting and watches a one-cycle start-of-frame tick. For periodic endpoints (interrupt and isochronous) it raises a one-cycle poll request each time the programmed number of frames has gone by. For bulk endpoints it counts frames while the device keeps answering with NAK handshakes. It raises a sticky timeout flag once that run of NAKs has lasted the programmed limit.

The same setting means different things for each transfer kind. Interrupt endpoints use it as a plain frame count. Isochronous endpoints and the bulk NAK limit use it as an exponent. A setting that is not legal for the selected kind raises a configuration-error output and silences both timing outputs.

Top module: `usb_ep_frame_timer`

## Requirements
- R1: The interval setting resets to 0x00. A write with `cfg_we` high stores `cfg_wdata`, and `cfg_rdata` shows the stored value from the next cycle on.
- R2: With `xfer_type` = 0 (interrupt) and setting m in 1..255, `poll_due` pulses on every m-th counted frame tick, counted from the last restart.
- R3: With `xfer_type` = 1 (isochronous) and m in 1..16, `poll_due` pulses on every 2^(m-1)-th counted frame tick, counted from the last restart.
- R4: With `xfer_type` = 2 (bulk) and m in 2..16, frame ticks are counted once a NAK has been seen. `nak_timeout` rises the cycle after the 2^(m-1)-th such tick and stays high until it is cleared.
- R5: In bulk mode, a setting of 0 or 1 never raises `nak_timeout`, however long the NAKs go on, and is not flagged as invalid.
- R6: `cfg_invalid` is high for interrupt with m = 0, isochronous with m = 0 or m > 16, bulk with m > 16, and for `xfer_type` = 3. While it is high, `poll_due` and `nak_timeout` stay low.
- R7: In bulk mode, a handshake that is not a NAK, or a `xfer_start` pulse, clears the NAK frame count. `xfer_start` or `timeout_clr` clears `nak_timeout`.
- R8: A register write or a change of `xfer_type` restarts the frame count from zero and clears the NAK state and the timeout.
- R9: `poll_due` is high only in a cycle in which `sof_tick` is high, and never in a cycle that restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the interval setting |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Stored interval setting |
| xfer_type | input | 2 | 0 interrupt, 1 isochronous, 2 bulk, 3 reserved |
| sof_tick | input | 1 | One-cycle start-of-frame tick |
| hs_valid | input | 1 | A handshake was received this cycle |
| hs_is_nak | input | 1 | The received handshake is a NAK |
| xfer_start | input | 1 | A new transfer begins |
| timeout_clr | input | 1 | Clears the NAK timeout flag |
| poll_due | output | 1 | One-cycle poll request (periodic modes) |
| nak_timeout | output | 1 | Sticky NAK-limit flag (bulk mode) |
| cfg_invalid | output | 1 | Setting is reserved for the selected kind |

## Verification
Periodic modes are run with a tick on every cycle and with ticks spaced several cycles apart. This shows that the count follows frames and not clocks. Linear and exponent decoding are separated by the settings 1, 3, 5 and 16, including the 32768-frame isochronous period. Bulk runs cover a steady NAK stream up to the timeout, an ACK and a new transfer part-way through the count, and a clear while NAKs continue. Restarts by write and by a change of kind part-way through a period, together with reserved and disabling settings, show whether the outputs are suppressed and whether the count starts again from zero.

// File: rtl/usb_ept_pkg.sv
package usb_ept_pkg;

  typedef enum logic [1:0] {
    XF_INTR = 2'd0,
    XF_ISOC = 2'd1,
    XF_BULK = 2'd2,
    XF_RSVD = 2'd3
  } xfer_e;

endpackage

// File: rtl/ept_mode_decode.sv
module ept_mode_decode
  import usb_ept_pkg::*;
#(
  parameter int IVL_W = 8,
  parameter int CNT_W = 16
) (
  input  logic [IVL_W-1:0] ivl,
  input  xfer_e            xtype,
  output logic             periodic,
  output logic             bulk_en,
  output logic             cfg_ok,
  output logic [CNT_W-1:0] target
);

  localparam int MAX_CODE = CNT_W;
  localparam int EXP_W    = $clog2(CNT_W);

  logic             code_ok;
  logic [EXP_W-1:0] expo;
  logic [CNT_W-1:0] pow_val;
  logic [CNT_W-1:0] lin_val;

  // exponent codes 1..MAX_CODE map to 2^(m-1); low bits wrap for m = MAX_CODE
  always_comb begin
    code_ok = (ivl != '0) && (ivl <= IVL_W'(MAX_CODE));
    expo    = ivl[EXP_W-1:0] - EXP_W'(1);
    pow_val = {{(CNT_W-1){1'b0}}, 1'b1} << expo;
    lin_val = CNT_W'(ivl);
  end

  always_comb begin
    periodic = 1'b0;
    bulk_en  = 1'b0;
    cfg_ok   = 1'b0;
    target   = '0;
    unique case (xtype)
      XF_INTR: begin
        periodic = 1'b1;
        cfg_ok   = (ivl != '0);
        target   = lin_val;
      end
      XF_ISOC: begin
        periodic = 1'b1;
        cfg_ok   = code_ok;
        target   = pow_val;
      end
      XF_BULK: begin
        cfg_ok   = (ivl <= IVL_W'(MAX_CODE));
        bulk_en  = code_ok && (ivl != IVL_W'(1));
        target   = pow_val;
      end
      default: begin
        cfg_ok   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ept_interval_reg.sv
module ept_interval_reg
  import usb_ept_pkg::*;
#(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IVL_W-1:0] wdata,
  input  xfer_e            xtype,
  output logic [IVL_W-1:0] ivl,
  output logic             restart
);

  logic [IVL_W-1:0] ivl_q, ivl_d;
  xfer_e            type_q;

  always_comb begin
    ivl_d = ivl_q;
    if (we) ivl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      type_q <= XF_INTR;
    end else begin
      ivl_q  <= ivl_d;
      type_q <= xtype;
    end
  end

  assign ivl     = ivl_q;
  assign restart = we || (xtype != type_q);

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ivl == $past(wdata)));

  p_hold_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ivl));

endmodule

// File: rtl/ept_frame_counter.sv
module ept_frame_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             periodic,
  input  logic             bulk_en,
  input  logic             cfg_ok,
  input  logic [CNT_W-1:0] target,
  input  logic             sof_tick,
  input  logic             hs_valid,
  input  logic             hs_is_nak,
  input  logic             xfer_start,
  input  logic             timeout_clr,
  output logic             poll_due,
  output logic             nak_timeout
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             nak_q, nak_d;
  logic             to_q, to_d;
  logic             hit;

  always_comb begin
    cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    hit     = (cnt_inc == target);
  end

  always_comb begin
    cnt_d = cnt_q;
    nak_d = nak_q;
    to_d  = to_q;
    if (restart) begin
      cnt_d = '0;
      nak_d = 1'b0;
      to_d  = 1'b0;
    end else if (periodic) begin
      if (cfg_ok && sof_tick) cnt_d = hit ? '0 : cnt_inc;
    end else if (xfer_start) begin
      cnt_d = '0;
      nak_d = 1'b0;
      to_d  = 1'b0;
    end else if (hs_valid && !hs_is_nak) begin
      cnt_d = '0;
      nak_d = 1'b0;
    end else begin
      if (hs_valid) nak_d = 1'b1;
      if (timeout_clr) to_d = 1'b0;
      if (sof_tick && nak_q && bulk_en && (cnt_q != target)) begin
        cnt_d = cnt_inc;
        if (hit) to_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nak_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      nak_q <= nak_d;
      to_q  <= to_d;
    end
  end

  assign poll_due    = periodic && cfg_ok && sof_tick && !restart && hit;
  assign nak_timeout = to_q && cfg_ok;

  p_poll_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    poll_due |-> sof_tick);

  p_outputs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> (!poll_due && !nak_timeout));

  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0) && !nak_timeout);

  p_timeout_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_timeout && !timeout_clr && !xfer_start && !restart) |=> nak_timeout);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && hs_valid && !hs_is_nak && !restart) |=> (cnt_q == '0));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && cfg_ok && !restart) |-> (cnt_q < target));

  p_bulk_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && !bulk_en && !restart) |=> !nak_timeout);

endmodule

// File: rtl/usb_ep_frame_timer.sv
module usb_ep_frame_timer
  import usb_ept_pkg::*;
#(
  parameter int IVL_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IVL_W-1:0] cfg_wdata,
  output logic [IVL_W-1:0] cfg_rdata,
  input  logic [1:0]       xfer_type,
  input  logic             sof_tick,
  input  logic             hs_valid,
  input  logic             hs_is_nak,
  input  logic             xfer_start,
  input  logic             timeout_clr,
  output logic             poll_due,
  output logic             nak_timeout,
  output logic             cfg_invalid
);

  xfer_e            xtype;
  logic [IVL_W-1:0] ivl;
  logic             restart;
  logic             periodic, bulk_en, cfg_ok;
  logic [CNT_W-1:0] target;

  assign xtype = xfer_e'(xfer_type);

  ept_interval_reg #(.IVL_W(IVL_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .xtype   (xtype),
    .ivl     (ivl),
    .restart (restart)
  );

  ept_mode_decode #(.IVL_W(IVL_W), .CNT_W(CNT_W)) u_dec (
    .ivl      (ivl),
    .xtype    (xtype),
    .periodic (periodic),
    .bulk_en  (bulk_en),
    .cfg_ok   (cfg_ok),
    .target   (target)
  );

  ept_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .periodic    (periodic),
    .bulk_en     (bulk_en),
    .cfg_ok      (cfg_ok),
    .target      (target),
    .sof_tick    (sof_tick),
    .hs_valid    (hs_valid),
    .hs_is_nak   (hs_is_nak),
    .xfer_start  (xfer_start),
    .timeout_clr (timeout_clr),
    .poll_due    (poll_due),
    .nak_timeout (nak_timeout)
  );

  assign cfg_rdata   = ivl;
  assign cfg_invalid = !cfg_ok;

  p_bulk_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_type == 2'd2 && cfg_rdata <= 8'd16) |-> !cfg_invalid);

endmodule

// File: tb/usb_ep_frame_timer_test.sv
module usb_ep_frame_timer_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, sof_tick, hs_valid, hs_is_nak, xfer_start, timeout_clr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [1:0] xfer_type;
  logic       poll_due, nak_timeout, cfg_invalid;

  int n_run  = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // reference model state
  int m_ivl, m_cnt, m_nak, m_to, m_tprev;
  int n_polls;

  always #(CLK_P/2) clk = ~clk;

  usb_ep_frame_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .xfer_type(xfer_type), .sof_tick(sof_tick),
    .hs_valid(hs_valid), .hs_is_nak(hs_is_nak), .xfer_start(xfer_start),
    .timeout_clr(timeout_clr), .poll_due(poll_due),
    .nak_timeout(nak_timeout), .cfg_invalid(cfg_invalid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  // decode the setting from the requirements
  function automatic void mdl_cfg(output bit ok, output bit per, output bit ben,
                                  output int tgt);
    int t = int'(xfer_type);
    ok = 0; per = 0; ben = 0; tgt = 0;
    if (t == 0) begin
      per = 1; ok = (m_ivl != 0); tgt = m_ivl;
    end else if (t == 1) begin
      per = 1; ok = (m_ivl >= 1 && m_ivl <= 16);
      if (ok) tgt = 1 << (m_ivl - 1);
    end else if (t == 2) begin
      ok = (m_ivl <= 16); ben = (m_ivl >= 2 && m_ivl <= 16);
      if (ben) tgt = 1 << (m_ivl - 1);
    end
  endfunction

  task automatic compare();
    bit ok, per, ben; int tgt; bit rs; bit e_poll;
    mdl_cfg(ok, per, ben, tgt);
    rs = cfg_we || (int'(xfer_type) != m_tprev);
    e_poll = per && ok && sof_tick && !rs && (m_cnt + 1 == tgt);
    chk(poll_due == e_poll, cur_req, "poll_due", int'(poll_due), int'(e_poll));
    chk(nak_timeout == (m_to != 0 && ok), cur_req, "nak_timeout",
        int'(nak_timeout), int'(m_to != 0 && ok));
    chk(cfg_invalid == !ok, cur_req, "cfg_invalid", int'(cfg_invalid), int'(!ok));
    chk(int'(cfg_rdata) == m_ivl, cur_req, "cfg_rdata", int'(cfg_rdata), m_ivl);
    if (poll_due) n_polls++;
  endtask

  task automatic update();
    bit ok, per, ben; int tgt; bit rs;
    mdl_cfg(ok, per, ben, tgt);
    rs = cfg_we || (int'(xfer_type) != m_tprev);
    if (rs) begin
      m_cnt = 0; m_nak = 0; m_to = 0;
    end else if (per) begin
      if (ok && sof_tick) m_cnt = (m_cnt + 1 == tgt) ? 0 : m_cnt + 1;
    end else if (xfer_start) begin
      m_cnt = 0; m_nak = 0; m_to = 0;
    end else if (hs_valid && !hs_is_nak) begin
      m_cnt = 0; m_nak = 0;
    end else begin
      int old_nak = m_nak;
      if (hs_valid) m_nak = 1;
      if (timeout_clr) m_to = 0;
      if (sof_tick && old_nak != 0 && ben && m_cnt != tgt) begin
        m_cnt++;
        if (m_cnt == tgt) m_to = 1;
      end
    end
    if (cfg_we) m_ivl = int'(cfg_wdata);
    m_tprev = int'(xfer_type);
  endtask

  task automatic tick();
    #(CLK_P/4);
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
    cfg_we = 0; sof_tick = 0; hs_valid = 0; hs_is_nak = 0;
    xfer_start = 0; timeout_clr = 0;
  endtask

  task automatic wr(input int v);
    cfg_we = 1; cfg_wdata = 8'(v); tick();
  endtask

  task automatic frames(input int n, input int gap);
    for (int i = 0; i < n * gap; i++) begin
      sof_tick = ((i % gap) == gap - 1);
      tick();
    end
  endtask

  task automatic nak_frames(input int n);
    for (int i = 0; i < n; i++) begin
      hs_valid = 1; hs_is_nak = 1; tick();
      sof_tick = 1; tick();
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = 0; xfer_type = 0; sof_tick = 0;
    hs_valid = 0; hs_is_nak = 0; xfer_start = 0; timeout_clr = 0;
    m_ivl = 0; m_cnt = 0; m_nak = 0; m_to = 0; m_tprev = 0; n_polls = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset value and readback; interrupt with m=0 is reserved (R6)
    cur_req = "R1";
    tick();
    chk(cfg_rdata == 8'h00, "R1", "reset rdata", int'(cfg_rdata), 0);
    chk(cfg_invalid == 1, "R6", "intr m=0 invalid", int'(cfg_invalid), 1);
    wr(8'hA5); tick();
    chk(cfg_rdata == 8'hA5, "R1", "readback", int'(cfg_rdata), 8'hA5);

    // R2 interrupt linear periods
    cur_req = "R2";
    wr(3); n_polls = 0; frames(12, 1);
    chk(n_polls == 4, "R2", "m=3 polls in 12 frames", n_polls, 4);
    n_polls = 0; frames(9, 3);
    chk(n_polls == 3, "R2", "m=3 spaced ticks", n_polls, 3);
    wr(1); n_polls = 0; frames(5, 2);
    chk(n_polls == 5, "R2", "m=1 polls", n_polls, 5);
    wr(255); n_polls = 0; frames(255, 1);
    chk(n_polls == 1, "R2", "m=255 polls", n_polls, 1);

    // R9 no poll without a tick
    cur_req = "R9";
    wr(2); frames(1, 1); frames(4, 1);

    // R3 isochronous exponent periods
    cur_req = "R3";
    xfer_type = 2'd1; wr(5); n_polls = 0; frames(48, 1);
    chk(n_polls == 3, "R3", "m=5 polls", n_polls, 3);
    wr(1); n_polls = 0; frames(6, 2);
    chk(n_polls == 6, "R3", "m=1 polls", n_polls, 6);
    wr(16); n_polls = 0; frames(32768, 1);
    chk(n_polls == 1, "R3", "m=16 polls", n_polls, 1);
    cur_req = "R6";
    wr(17); n_polls = 0; frames(40, 1);
    chk(n_polls == 0 && cfg_invalid, "R6", "isoc m=17 silent", n_polls, 0);
    wr(0); frames(5, 1);

    // R8 restart by write and by type change
    cur_req = "R8";
    xfer_type = 2'd1; wr(3); frames(3, 1);
    wr(3); n_polls = 0; frames(3, 1);
    chk(n_polls == 0, "R8", "write restart delays poll", n_polls, 0);
    frames(1, 1);
    chk(n_polls == 1, "R8", "poll after full period", n_polls, 1);
    frames(2, 1);
    xfer_type = 2'd0; n_polls = 0; frames(2, 1);
    chk(n_polls == 0, "R8", "type change restart", n_polls, 0);

    // R4 bulk NAK limit
    cur_req = "R4";
    xfer_type = 2'd2; wr(4);
    nak_frames(8); tick();
    chk(nak_timeout == 1, "R4", "timeout after 8 NAK frames", int'(nak_timeout), 1);
    nak_frames(3);
    chk(nak_timeout == 1, "R4", "timeout sticky", int'(nak_timeout), 1);
    cur_req = "R7";
    timeout_clr = 1; tick(); tick();
    chk(nak_timeout == 0, "R7", "timeout_clr", int'(nak_timeout), 0);
    xfer_start = 1; tick();
    nak_frames(5); hs_valid = 1; hs_is_nak = 0; tick();
    nak_frames(7); tick();
    chk(nak_timeout == 0, "R7", "ack restarted count", int'(nak_timeout), 0);
    nak_frames(1); tick();
    chk(nak_timeout == 1, "R7", "timeout after ack+8", int'(nak_timeout), 1);
    xfer_start = 1; tick();
    chk(nak_timeout == 0, "R7", "xfer_start clears", int'(nak_timeout), 0);
    cur_req = "R4";
    wr(2); nak_frames(2); tick();
    chk(nak_timeout == 1, "R4", "m=2 limit 2", int'(nak_timeout), 1);
    wr(16); nak_frames(16384); tick();
    chk(nak_timeout == 0, "R4", "m=16 half way", int'(nak_timeout), 0);
    nak_frames(16384); tick();
    chk(nak_timeout == 1, "R4", "m=16 limit", int'(nak_timeout), 1);

    // R5 disabled settings
    cur_req = "R5";
    wr(1); nak_frames(40); tick();
    chk(nak_timeout == 0 && !cfg_invalid, "R5", "m=1 disabled", int'(nak_timeout), 0);
    wr(0); nak_frames(40); tick();
    chk(nak_timeout == 0 && !cfg_invalid, "R5", "m=0 disabled", int'(nak_timeout), 0);

    // R6 reserved settings
    cur_req = "R6";
    wr(17); nak_frames(40); tick();
    chk(cfg_invalid == 1 && nak_timeout == 0, "R6", "bulk m=17", int'(cfg_invalid), 1);
    xfer_type = 2'd3; wr(3); frames(10, 1);
    chk(cfg_invalid == 1, "R6", "reserved kind", int'(cfg_invalid), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule